// File: doc/BRIEF.md
# Interrupt Enable Gate with One-Instruction Shadow

This block holds a small CPU's status word, including its global interrupt enable bit. On every instruction boundary it decides whether a pending maskable request may be taken. The status word can be loaded through a write port. Any load that turns the enable bit on from off opens a shadow, which blocks acceptance until one more instruction has retired. As a result, the instruction placed right after an enable always runs, even when a request is already waiting.

The block takes one retire strobe for each completed instruction and one pending-request level. Its outputs are the registered status word and a one-cycle accept pulse. In the clock edge that raises the accept pulse, the block also clears the enable bit. This stops the handler from being entered again before software enables interrupts once more.

A retire strobe in the same cycle as the enabling write belongs to the writing instruction itself. The first retire strobe after that cycle is the shadowed instruction.

Top module: `intr_enable_gate`

## Requirements
- R1: After a synchronous reset, `stat_q` is 0 and `take_o` is 0.
- R2: When `stat_we` is 1, all bits of `stat_wd` appear on `stat_q` after the next rising edge, unless R10 applies.
- R3: The enable bit is bit 3 (weight 0x0008). When `instr_ret` and `irq_pend` are both 1, the enable bit is 1 and no shadow is open, `take_o` is 1 for the cycle after that edge.
- R4: An acceptance clears bit 3 of `stat_q` on the same edge that raises `take_o`, and leaves every other bit unchanged.
- R5: No acceptance happens while `instr_ret` is 0, while `irq_pend` is 0, or while bit 3 is 0.
- R6: A write that sets bit 3 while it is 0 opens a shadow. The first `instr_ret` after the write cycle gives no acceptance and closes the shadow. A later retire with a pending request is accepted.
- R7: The shadow opens for any written value with bit 3 set, whatever the other bits hold.
- R8: A write with bit 3 set while bit 3 is already 1 does not open a shadow.
- R9: A write with bit 3 clear blocks acceptance in its own cycle and cancels any open shadow. A later enabling write opens a full new shadow.
- R10: If a write and an acceptance fall on the same edge, `stat_q` takes the written bits except bit 3, which is cleared.
- R11: `take_o` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_we | input | 1 | Status word write enable |
| stat_wd | input | 16 | Status word write data |
| instr_ret | input | 1 | One instruction retired this cycle |
| irq_pend | input | 1 | A maskable request is pending |
| stat_q | output | 16 | Registered status word |
| take_o | output | 1 | Interrupt accept pulse |

## Verification
The acceptance path is tried with every single missing condition: no retire, no request, enable off, and shadow open. Each case must give no pulse, while the case with all conditions present must give a pulse. This separates a gate that ignores any one term from a correct one. Enabling writes are applied from the off state, from the on state, with other bits set, and in the same cycle as a retire. These show whether the shadow opens only on a real off-to-on change and whether the writer's own retire is wrongly counted. Clearing writes are placed during an open shadow and in the same cycle as a would-be acceptance. Together with a write that coincides with an acceptance, they check the cancel and merge rules.

// File: rtl/igate_pkg.sv
package igate_pkg;
  localparam int unsigned STAT_W_DEF   = 16;
  localparam int unsigned EN_POS_DEF   = 3;
  localparam int unsigned SHADOW_N_DEF = 1;
endpackage

// File: rtl/igate_stat_reg.sv
module igate_stat_reg #(
  parameter int unsigned STAT_W = igate_pkg::STAT_W_DEF,
  parameter int unsigned EN_POS = igate_pkg::EN_POS_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              accept,
  output logic [STAT_W-1:0] stat_q
);
  logic [STAT_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_en) stat_d = wr_data;
    if (accept) stat_d[EN_POS] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !accept) |=> (stat_q == $past(wr_data)));  // R2
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    accept |=> !stat_q[EN_POS]);  // R4
endmodule

// File: rtl/igate_shadow.sv
module igate_shadow #(
  parameter int unsigned SHADOW_N = igate_pkg::SHADOW_N_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_en_bit,
  input  logic en_q,
  input  logic retire,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(SHADOW_N + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(SHADOW_N);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                               cnt_q <= '0;
    else if (wr_en && !wr_en_bit)          cnt_q <= '0;
    else if (wr_en && wr_en_bit && !en_q)  cnt_q <= LOAD_V;
    else if (retire && cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_SET_OPENS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_en_bit && !en_q) |=> (cnt_q == LOAD_V));  // R6
  AST_CLEAR_CANCELS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_en_bit) |=> !busy);  // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !busy);  // R1
endmodule

// File: rtl/igate_accept.sv
module igate_accept (
  input  logic clk,
  input  logic rst,
  input  logic retire,
  input  logic pend,
  input  logic en_q,
  input  logic shadow_busy,
  input  logic wr_en,
  input  logic wr_en_bit,
  output logic accept,
  output logic take_q
);
  logic clr_now;

  always_comb begin
    clr_now = wr_en && !wr_en_bit;
    accept  = retire && pend && en_q && !shadow_busy && !clr_now;
  end

  always_ff @(posedge clk) begin
    if (rst) take_q <= 1'b0;
    else     take_q <= accept;
  end

  AST_TAKE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    take_q |-> $past(retire && pend));  // R5
  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    take_q |=> !take_q);  // R11
endmodule

// File: rtl/intr_enable_gate.sv
module intr_enable_gate #(
  parameter int unsigned STAT_W   = igate_pkg::STAT_W_DEF,
  parameter int unsigned EN_POS   = igate_pkg::EN_POS_DEF,
  parameter int unsigned SHADOW_N = igate_pkg::SHADOW_N_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wd,
  input  logic              instr_ret,
  input  logic              irq_pend,
  output logic [STAT_W-1:0] stat_q,
  output logic              take_o
);
  logic accept;
  logic shadow_busy;
  logic wr_en_bit;
  logic en_q;

  assign wr_en_bit = stat_wd[EN_POS];
  assign en_q      = stat_q[EN_POS];

  igate_stat_reg #(.STAT_W(STAT_W), .EN_POS(EN_POS)) u_stat (
    .clk(clk), .rst(rst), .wr_en(stat_we), .wr_data(stat_wd),
    .accept(accept), .stat_q(stat_q)
  );

  igate_shadow #(.SHADOW_N(SHADOW_N)) u_shadow (
    .clk(clk), .rst(rst), .wr_en(stat_we), .wr_en_bit(wr_en_bit),
    .en_q(en_q), .retire(instr_ret), .busy(shadow_busy)
  );

  igate_accept u_accept (
    .clk(clk), .rst(rst), .retire(instr_ret), .pend(irq_pend),
    .en_q(en_q), .shadow_busy(shadow_busy), .wr_en(stat_we),
    .wr_en_bit(wr_en_bit), .accept(accept), .take_q(take_o)
  );

  AST_SHADOW_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    shadow_busy |=> !take_o);  // R6
  AST_NO_TAKE_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !take_o);  // R5
  AST_TAKE_WITH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !en_q);  // R4
endmodule

// File: tb/intr_enable_gate_tb_top.sv
`timescale 1ns/1ps
module intr_enable_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        stat_we;
  logic [15:0] stat_wd;
  logic        instr_ret;
  logic        irq_pend;
  logic [15:0] stat_q;
  logic        take_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intr_enable_gate dut_i (
    .clk(clk), .rst(rst), .stat_we(stat_we), .stat_wd(stat_wd),
    .instr_ret(instr_ret), .irq_pend(irq_pend),
    .stat_q(stat_q), .take_o(take_o)
  );

  // fields: we, wd[16], ret, pend, exp_stat[16], exp_take, req[4]
  localparam int NV = 21;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 16'h0030, 1'b0, 1'b0, 16'h0030, 1'b0, 4'd2},  // R2 plain load
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'h0030, 1'b0, 4'd5},  // R5 enable off
    {1'b1, 16'h0038, 1'b1, 1'b1, 16'h0038, 1'b0, 4'd6},  // R6 enable, writer retire
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'h0038, 1'b0, 4'd6},  // R6 shadowed retire
    {1'b0, 16'h0000, 1'b0, 1'b1, 16'h0038, 1'b0, 4'd5},  // R5 no retire
    {1'b0, 16'h0000, 1'b1, 1'b0, 16'h0038, 1'b0, 4'd5},  // R5 no request
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'h0030, 1'b1, 4'd3},  // R3 R4 accept
    {1'b0, 16'h0000, 1'b0, 1'b1, 16'h0030, 1'b0, 4'd11}, // R11 pulse ends
    {1'b1, 16'h00FF, 1'b0, 1'b0, 16'h00FF, 1'b0, 4'd7},  // R7 enable with other bits
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'h00FF, 1'b0, 4'd7},  // R7 shadowed
    {1'b1, 16'h00F8, 1'b0, 1'b0, 16'h00F8, 1'b0, 4'd8},  // R8 re-set while on
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'h00F0, 1'b1, 4'd8},  // R8 no new shadow
    {1'b1, 16'h0008, 1'b0, 1'b0, 16'h0008, 1'b0, 4'd6},  // R6 open shadow
    {1'b1, 16'h0000, 1'b1, 1'b1, 16'h0000, 1'b0, 4'd9},  // R9 clear cancels
    {1'b1, 16'h0008, 1'b0, 1'b0, 16'h0008, 1'b0, 4'd9},  // R9 new shadow
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'h0008, 1'b0, 4'd9},  // R9 full shadow again
    {1'b1, 16'h1238, 1'b1, 1'b1, 16'h1230, 1'b1, 4'd10}, // R10 write + accept
    {1'b0, 16'h0000, 1'b0, 1'b0, 16'h1230, 1'b0, 4'd11}, // R11 single pulse
    {1'b1, 16'h0008, 1'b0, 1'b0, 16'h0008, 1'b0, 4'd6},  // R6 open shadow
    {1'b0, 16'h0000, 1'b1, 1'b0, 16'h0008, 1'b0, 4'd6},  // R6 shadow closes
    {1'b1, 16'h0004, 1'b1, 1'b1, 16'h0004, 1'b0, 4'd9}   // R9 clear blocks same cycle
  };

  task automatic check(input string req, input logic [15:0] act_s, input logic act_t,
                       input logic [15:0] exp_s, input logic exp_t);
    checks++;
    if (act_s !== exp_s || act_t !== exp_t) begin
      errors++;
      $display("FAIL %s: stat_q=%h take_o=%b expected stat_q=%h take_o=%b",
               req, act_s, act_t, exp_s, exp_t);
    end
  endtask

  task automatic step(input logic we, input logic [15:0] wd, input logic ret, input logic pd);
    @(negedge clk);
    stat_we = we; stat_wd = wd; instr_ret = ret; irq_pend = pd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; stat_we = 1'b0; stat_wd = '0; instr_ret = 1'b0; irq_pend = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", stat_q, take_o, 16'h0000, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][39], VEC[i][38:23], VEC[i][22], VEC[i][21]);
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), stat_q, take_o,
            VEC[i][20:5], VEC[i][4]);
    end

    // R1: reset in the middle of an open shadow and a pending request
    step(1'b1, 16'h00AB, 1'b0, 1'b1);
    check("R2", stat_q, take_o, 16'h00AB, 1'b0);
    @(negedge clk);
    rst = 1'b1; stat_we = 1'b0; instr_ret = 1'b1;
    @(posedge clk); #1;
    check("R1", stat_q, take_o, 16'h0000, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 16'h0000, 1'b1, 1'b1);
    check("R5", stat_q, take_o, 16'h0000, 1'b0);

    // R3: back-to-back accept after re-enable and one shadowed retire
    step(1'b1, 16'h8008, 1'b0, 1'b1);
    step(1'b0, 16'h0000, 1'b1, 1'b1);
    check("R6", stat_q, take_o, 16'h8008, 1'b0);
    step(1'b0, 16'h0000, 1'b1, 1'b1);
    check("R3", stat_q, take_o, 16'h8000, 1'b1);
    step(1'b0, 16'h0000, 1'b1, 1'b1);
    check("R11", stat_q, take_o, 16'h8000, 1'b0);

    step(1'b0, 16'h0000, 1'b0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule